// File: doc/BRIEF.md
# Integer-N Synthesiser Digital Core

This block holds the digital half of an integer-N frequency synthesiser. It runs on one core clock. The reference oscillator and the VCO reach it as single-cycle event strobes (`ref_tick`, `vco_tick`), already brought into the core clock domain. A programmable reference divider turns reference events into comparison events, which sets the step size of the loop. A programmable feedback divider does the same for the VCO events. A compile-time parameter can place a fixed halving stage ahead of the feedback divider: this is the main-loop variant, whose output frequency is twice the feedback ratio over the reference ratio, times the reference. Without that stage it is the auxiliary variant.

A phase-frequency detector compares the two divided event streams and drives pump-up and pump-down requests to an external charge pump. It is a three-state machine:
- `PD_IDLE` goes to `PD_UP` on *ref-first* and to `PD_DN` on *fb-first*.
- `PD_IDLE` stays where it is on *both-together*.
- `PD_UP` returns to `PD_IDLE` on *fb-arrives*.
- `PD_DN` returns to `PD_IDLE` on *ref-arrives*.

Each return to idle closes one comparison and reports how many core cycles the request stayed high. A lock monitor with states `LK_SEARCH` and `LK_LOCKED` counts consecutive narrow comparisons:
- *streak-complete* moves it from `LK_SEARCH` to `LK_LOCKED`.
- *wide-pulse* drops it from `LK_LOCKED` to `LK_SEARCH`.

The *wide-pulse* transition sets a sticky flag. The flag can drive an interrupt so the host can stop transmitting.

Top module: `pll_digital_core`

## Requirements
- R1: A reference ratio value R gives one comparison event every R reference events; a value of 0 or 1 gives one comparison event per reference event. The first reference event after reset produces a comparison event.
- R2: With the halving stage present (PRESCALE=1, the default), a feedback ratio value F gives one feedback event every 2·F VCO events, with 0 or 1 treated as 1. The first VCO event after reset produces a feedback event. With PRESCALE=0 the period is F VCO events.
- R3: A ratio written while a divider is part-way through a period does not change that period; the divider counts down undisturbed and loads the new value at its next terminal count.
- R4: A comparison event with no feedback event raises `pd_up` from the next cycle. A feedback event with no comparison event raises `pd_dn` from the next cycle. A raised request falls one cycle after the other event arrives. Coincident events raise neither request, and `pd_up` and `pd_dn` are never high together.
- R5: `locked` rises when 16 consecutive comparisons have each had a request width below the threshold. The width is the number of core cycles the request stayed high minus one, and 0 for coincident events. One comparison at or above the threshold clears `locked`.
- R6: Register map, written through `wr_*` and read combinationally through `rd_addr`/`rd_data`:
  - address 0 holds the reference ratio; address 1 holds the feedback ratio; both reset to 1.
  - address 2 holds the threshold in bits [7:0], reset 4, and the interrupt enable in bit 8, reset 0.
  - address 3 holds status: bit 0 is lock and bit 1 is the sticky flag.
- R7: The sticky flag is set on the *wide-pulse* transition. A write to address 3 with bit 1 at 1 clears it. If that write falls in the same cycle as a *wide-pulse* transition, the flag stays set.
- R8: `irq` is high exactly when the sticky flag is set and the interrupt enable is 1.
- R9: After reset `pd_up`, `pd_dn`, `locked`, `irq` and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference oscillator edge |
| vco_tick | input | 1 | One-cycle strobe per VCO edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pd_up | output | 1 | Charge pump up request |
| pd_dn | output | 1 | Charge pump down request |
| locked | output | 1 | Lock indication |
| irq | output | 1 | Out-of-lock interrupt |

## Verification
The hardest case to reach from the ports is a host clear of the sticky flag landing in the same cycle as the loss of lock. The bench first runs aligned event streams for an exact number of cycles, which leaves the halving stage and both dividers at a known phase with lock held. It then sends a lone reference event, waits until the up request is far wider than the threshold, and in one cycle issues the closing VCO event together with the clear write. Lock counting near its boundary is reached the same way, by stopping the aligned run after exactly 15 and then 16 comparisons.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DN   = 2'd2
    } pd_state_t;

    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_LOCKED = 1'b1
    } lk_state_t;

    localparam logic [1:0] ADDR_REF_RATIO = 2'd0;
    localparam logic [1:0] ADDR_FB_RATIO  = 2'd1;
    localparam logic [1:0] ADDR_CTRL      = 2'd2;
    localparam logic [1:0] ADDR_STATUS    = 2'd3;

endpackage

// File: rtl/pll_ratio_div.sv
module pll_ratio_div #(
    parameter int RATIO_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [RATIO_W-1:0] ratio,
    output logic               pulse
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] eff_ratio;
    logic               reload;

    assign reload    = tick && (cnt == '0);
    assign eff_ratio = (ratio == '0) ? RATIO_W'(1) : ratio;
    assign pulse     = reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (reload) begin
            cnt <= eff_ratio - 1'b1;
        end else if (tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R3: a part-way period counts down regardless of register writes
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R3: without an event the count is frozen
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> $stable(cnt));

endmodule

// File: rtl/pll_prescale2.sv
module pll_prescale2 (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic pulse
);
    logic phase;

    assign pulse = tick && !phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else if (tick) begin
            phase <= ~phase;
        end
    end

    // R2: two successive prescaler outputs are never in adjacent events
    a_r2_halves: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !(tick && pulse));

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
    import pll_core_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_ev,
    input  logic               fb_ev,
    output logic               up,
    output logic               dn,
    output logic               done,
    output logic [WIDTH_W-1:0] width
);
    pd_state_t          state, state_nxt;
    logic [WIDTH_W-1:0] wcnt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PD_IDLE: begin
                if (ref_ev && !fb_ev)      state_nxt = PD_UP;  // ref-first
                else if (fb_ev && !ref_ev) state_nxt = PD_DN;  // fb-first
            end
            PD_UP:   if (fb_ev)  state_nxt = PD_IDLE;          // fb-arrives
            PD_DN:   if (ref_ev) state_nxt = PD_IDLE;          // ref-arrives
            default: state_nxt = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PD_IDLE;
            wcnt  <= '0;
        end else begin
            state <= state_nxt;
            if (state == PD_IDLE)      wcnt <= '0;
            else if (wcnt != '1)       wcnt <= wcnt + 1'b1;
        end
    end

    always_comb begin
        up    = (state == PD_UP);
        dn    = (state == PD_DN);
        width = wcnt;
        unique case (state)
            PD_IDLE: done = ref_ev && fb_ev;
            PD_UP:   done = fb_ev;
            PD_DN:   done = ref_ev;
            default: done = 1'b0;
        endcase
    end

    // R4: requests are mutually exclusive
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    // R4: a lone reference event from idle raises up on the next cycle
    a_r4_ref_leads: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && ref_ev && !fb_ev) |=> (up && !dn));

    // R4: coincident events from idle raise nothing
    a_r4_coincident: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && ref_ev && fb_ev) |=> (!up && !dn));

endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon
    import pll_core_pkg::*;
#(
    parameter int WIDTH_W     = 8,
    parameter int LOCK_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done,
    input  logic [WIDTH_W-1:0] width,
    input  logic [WIDTH_W-1:0] thresh,
    output logic               locked,
    output logic               lost
);
    localparam int GC_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

    lk_state_t       state, state_nxt;
    logic [GC_W-1:0] good_cnt;
    logic            narrow;

    assign narrow = (width < thresh);

    always_comb begin
        state_nxt = state;
        unique case (state)
            LK_SEARCH: if (done && narrow && good_cnt == GC_W'(LOCK_CYCLES - 1))
                           state_nxt = LK_LOCKED;                 // streak-complete
            LK_LOCKED: if (done && !narrow) state_nxt = LK_SEARCH; // wide-pulse
            default:   state_nxt = LK_SEARCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= LK_SEARCH;
            good_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (done) begin
                if (!narrow)                     good_cnt <= '0;
                else if (state == LK_SEARCH)     good_cnt <= good_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        locked = (state == LK_LOCKED);
        lost   = (state == LK_LOCKED) && done && !narrow;
    end

    // R5: lock is only gained on a comparison that closes
    a_r5_gain_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(done));

endmodule

// File: rtl/pll_digital_core.sv
module pll_digital_core
    import pll_core_pkg::*;
#(
    parameter int RATIO_W     = 12,
    parameter int WIDTH_W     = 8,
    parameter int DATA_W      = 16,
    parameter int LOCK_CYCLES = 16,
    parameter bit PRESCALE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              vco_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pd_up,
    output logic              pd_dn,
    output logic              locked,
    output logic              irq
);
    localparam logic [WIDTH_W-1:0] THRESH_RST = WIDTH_W'(4);

    logic [RATIO_W-1:0] ref_ratio, fb_ratio;
    logic [WIDTH_W-1:0] thresh;
    logic               irq_en, flag, clr_req;
    logic               ref_ev, fb_in, fb_ev, cmp_done, lost;
    logic [WIDTH_W-1:0] cmp_width;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data[DATA_W-1:RATIO_W];
    assign clr_req        = wr_en && (wr_addr == ADDR_STATUS) && wr_data[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ratio <= RATIO_W'(1);
            fb_ratio  <= RATIO_W'(1);
            thresh    <= THRESH_RST;
            irq_en    <= 1'b0;
            flag      <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_REF_RATIO) ref_ratio <= wr_data[RATIO_W-1:0];
            if (wr_en && wr_addr == ADDR_FB_RATIO)  fb_ratio  <= wr_data[RATIO_W-1:0];
            if (wr_en && wr_addr == ADDR_CTRL) begin
                thresh <= wr_data[WIDTH_W-1:0];
                irq_en <= wr_data[WIDTH_W];
            end
            if (lost)         flag <= 1'b1;
            else if (clr_req) flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_REF_RATIO: rd_data = DATA_W'(ref_ratio);
            ADDR_FB_RATIO:  rd_data = DATA_W'(fb_ratio);
            ADDR_CTRL:      rd_data = DATA_W'({irq_en, thresh});
            default:        rd_data = DATA_W'({flag, locked});
        endcase
        irq = flag && irq_en;
    end

    generate
        if (PRESCALE) begin : g_prescale
            pll_prescale2 i_pre (
                .clk(clk), .rst_n(rst_n), .tick(vco_tick), .pulse(fb_in)
            );
        end else begin : g_direct
            assign fb_in = vco_tick;
        end
    endgenerate

    pll_ratio_div #(.RATIO_W(RATIO_W)) i_ref_div (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .ratio(ref_ratio), .pulse(ref_ev)
    );

    pll_ratio_div #(.RATIO_W(RATIO_W)) i_fb_div (
        .clk(clk), .rst_n(rst_n), .tick(fb_in), .ratio(fb_ratio), .pulse(fb_ev)
    );

    pll_pfd #(.WIDTH_W(WIDTH_W)) i_pfd (
        .clk(clk), .rst_n(rst_n), .ref_ev(ref_ev), .fb_ev(fb_ev),
        .up(pd_up), .dn(pd_dn), .done(cmp_done), .width(cmp_width)
    );

    pll_lock_mon #(.WIDTH_W(WIDTH_W), .LOCK_CYCLES(LOCK_CYCLES)) i_lock (
        .clk(clk), .rst_n(rst_n), .done(cmp_done), .width(cmp_width),
        .thresh(thresh), .locked(locked), .lost(lost)
    );

    // R7: a clear in the same cycle as a loss leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && clr_req) |=> flag);

    // R7: the flag only rises out of a locked state
    a_r7_rise_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(locked));

endmodule

// File: tb/test_pll_digital_core.sv
module test_pll_digital_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0, vco_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, rd_data;
    logic        pd_up, pd_dn, locked, irq;

    int checks = 0, fails = 0, gcyc = 0;

    // rr, rf, ref event spacing, vco event spacing, expected lock
    localparam int VEC [5][5] = '{
        '{4, 2, 2, 2, 1},
        '{3, 1, 2, 3, 1},
        '{4, 3, 2, 2, 0},
        '{0, 0, 4, 2, 1},
        '{3, 1, 4, 4, 0}
    };

    pll_digital_core i_pll_digital_core (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pd_up(pd_up), .pd_dn(pd_dn), .locked(locked), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_tick = 1'b0; vco_tick = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic run(input int n, input int pref, input int pvco);
        for (int i = 0; i < n; i++) begin
            ref_tick = (gcyc % pref == 0);
            vco_tick = (gcyc % pvco == 0);
            gcyc++;
            @(negedge clk);
        end
        ref_tick = 1'b0; vco_tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int d;
        do_reset();

        // R9 / R6: reset state
        chk("R9 pd_up", pd_up, 0);
        chk("R9 pd_dn", pd_dn, 0);
        chk("R9 locked", locked, 0);
        chk("R9 irq", irq, 0);
        rd(2'd3, d); chk("R9 status", d, 0);
        rd(2'd0, d); chk("R6 ref ratio reset", d, 1);
        rd(2'd2, d); chk("R6 ctrl reset", d, 4);

        // R1 / R2 / R5: table of ratio and rate combinations
        for (int v = 0; v < 5; v++) begin
            do_reset();
            wr(2'd0, 16'(VEC[v][0]));
            wr(2'd1, 16'(VEC[v][1]));
            gcyc = 0;
            run(320, VEC[v][2], VEC[v][3]);
            chk($sformatf("R1 R2 R5 vector %0d lock", v), locked, VEC[v][4]);
        end

        // R5: lock boundary at 15 vs 16 comparisons
        do_reset();
        wr(2'd0, 16'd4); wr(2'd1, 16'd2);
        gcyc = 0;
        run(120, 2, 2);
        chk("R5 after 15 narrow comparisons", locked, 0);
        run(8, 2, 2);
        chk("R5 after 16 narrow comparisons", locked, 1);

        // R3: ratio changes mid-period keep the loop aligned
        run(4, 2, 2);
        wr(2'd0, 16'd8);
        run(2, 2, 2);
        wr(2'd1, 16'd4);
        run(200, 2, 2);
        chk("R3 lock kept after mid-period writes", locked, 1);
        rd(2'd3, d); chk("R3 no loss flagged", (d >> 1) & 1, 0);

        // R4: lead, lag and coincidence
        do_reset();
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
        chk("R4 ref leads up", pd_up, 1);
        chk("R4 ref leads dn", pd_dn, 0);
        vco_tick = 1'b1; @(negedge clk); vco_tick = 1'b0;
        chk("R4 up cleared by fb", pd_up, 0);
        vco_tick = 1'b1; @(negedge clk); vco_tick = 1'b0;
        chk("R2 second vco event absorbed", pd_dn, 0);
        vco_tick = 1'b1; @(negedge clk); vco_tick = 1'b0;
        chk("R4 fb leads dn", pd_dn, 1);
        chk("R4 fb leads up", pd_up, 0);
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
        chk("R4 dn cleared by ref", pd_dn, 0);
        vco_tick = 1'b1; @(negedge clk); vco_tick = 1'b0;
        ref_tick = 1'b1; vco_tick = 1'b1; @(negedge clk);
        ref_tick = 1'b0; vco_tick = 1'b0;
        chk("R4 coincident up", pd_up, 0);
        chk("R4 coincident dn", pd_dn, 0);

        // R7 / R8: loss of lock with a clear in the same cycle
        do_reset();
        gcyc = 0;
        run(200, 4, 2);
        chk("R5 locked before loss", locked, 1);
        ref_tick = 1'b1; @(negedge clk); ref_tick = 1'b0;
        repeat (10) @(negedge clk);
        vco_tick = 1'b1;
        wr(2'd3, 16'h0002);
        vco_tick = 1'b0;
        chk("R5 wide pulse clears lock", locked, 0);
        rd(2'd3, d); chk("R7 set wins over clear", (d >> 1) & 1, 1);
        chk("R8 irq masked when disabled", irq, 0);
        wr(2'd2, 16'h0104);
        chk("R8 irq with enable", irq, 1);
        wr(2'd3, 16'h0002);
        rd(2'd3, d); chk("R7 write-one clears flag", (d >> 1) & 1, 0);
        chk("R8 irq drops after clear", irq, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule